// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block is the target-side engine that returns one bit at a time to a debug host over a shared, open-drain, single-wire debug pin. The host starts every bit time with a falling edge on the line. The target sees that edge through a two-flop synchronizer and then completes the bit itself. To return a 0, the target pulls the line low for a fixed number of bus clocks and then drives it high for a short speedup pulse. The pulse sharpens the rising edge before the pin goes back to high impedance. To return a 1, the target leaves the line alone, and the external pull-up keeps it high.

Logic upstream presents the next bit with a one-cycle load strobe. The block then waits for the host edge. A done flag reports that the bit has been delivered and that the pin has been released. Command decoding, byte framing and host-side sampling belong to other blocks.

Top module: `sw_dbg_bit_tx`

## Requirements
- R1: While reset is asserted and after it is released, `drive_en` and `done` are 0.
- R2: After a load, the block drives nothing until the synchronized pin shows a high-to-low change. Until then it waits with `drive_en` at 0.
- R3: Suppose a 0 is loaded and the host pulls the pin low before clock edge k, so that edge k first samples it low. Then `drive_en`=1 with `drive_val`=0 takes effect after edge k+2 and lasts exactly LOW_CYCLES (default 13) bus clocks.
- R4: Right after the low period, the block drives `drive_val`=1 with `drive_en`=1 for exactly PULSE_CYCLES (default 1) clocks. It then sets `drive_en` to 0.
- R5: When a 0 is being returned, the line still reads low SAMPLE_CYCLE (default 10) clocks after the target's perceived start of the bit.
- R6: When a 1 is loaded, the block never asserts `drive_en`. It raises `done` after edge k+2.
- R7: `done` is never 1 while `drive_en` is 1. For a 0 bit it rises in the same cycle that the pin is released, after edge k+LOW_CYCLES+PULSE_CYCLES+2. A load clears it.
- R8: A falling edge on the pin while no bit is loaded (after reset, or after `done`) is ignored. `drive_en` stays 0 and `done` keeps its value.
- R9: A load strobe while a bit is being driven is ignored. The low and pulse lengths are unchanged, and no new bit is armed afterwards.
- R10: A second load before the host edge replaces the waiting bit, so the last value loaded is the one returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Level read back from the shared debug pin |
| load | input | 1 | One-cycle strobe that arms the next bit |
| load_bit | input | 1 | Bit value captured with `load` |
| drive_en | output | 1 | 1 enables the pin output driver |
| drive_val | output | 1 | Level driven when `drive_en` is 1 (0 = pull low, 1 = speedup high) |
| done | output | 1 | Bit delivered and pin released |

## Verification
The bench builds the block with its default parameters: a 13-clock low period, a one-clock speedup pulse, a host sample point at clock 10, and two synchronizer stages. With these values a whole bit fits in a window of about twenty clocks. Each cycle of that window can be recorded, so the exact first low cycle, the last low cycle, the single pulse cycle and the cycle where `done` rises are all observed directly. The short window also leaves room to inject loads during the low period and stray host edges after completion.

// File: rtl/sw_dbg_bit_pkg.sv
package sw_dbg_bit_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_LOW   = 2'd2,
      ST_PULSE = 2'd3
   } tx_state_t;
endpackage

// File: rtl/sw_dbg_bit_sync.sv
module sw_dbg_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic fall
);
   initial begin
      if (STAGES < 2) $error("sw_dbg_bit_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= pin_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain[STAGES-1];
   end

   assign fall = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/sw_dbg_bit_timer.sv
module sw_dbg_bit_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clr)              count <= '0;
      else if (count != CNT_MAX) count <= count + 1'b1;
   end
endmodule

// File: rtl/sw_dbg_bit_ctrl.sv
module sw_dbg_bit_ctrl
   import sw_dbg_bit_pkg::*;
#(
   parameter int LOW_CYCLES   = 13,
   parameter int PULSE_CYCLES = 1,
   parameter int CNT_W        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall,
   input  logic             load,
   input  logic             load_bit,
   input  logic [CNT_W-1:0] count,
   output logic             cnt_clr,
   output tx_state_t        state,
   output logic             done
);
   localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(LOW_CYCLES - 1);
   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'((PULSE_CYCLES > 0) ? PULSE_CYCLES - 1 : 0);
   localparam bit               HAS_PULSE  = (PULSE_CYCLES > 0);

   tx_state_t state_nx;
   logic      bit_q, bit_nx, done_nx;

   always_comb begin
      state_nx = state;
      bit_nx   = bit_q;
      done_nx  = done;
      cnt_clr  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (load) begin
               state_nx = ST_ARMED;
               bit_nx   = load_bit;
               done_nx  = 1'b0;
            end
         end
         ST_ARMED: begin
            if (fall) begin
               cnt_clr = 1'b1;
               if (bit_q) begin
                  state_nx = ST_IDLE;
                  done_nx  = 1'b1;
               end else begin
                  state_nx = ST_LOW;
               end
            end else if (load) begin
               bit_nx = load_bit;
            end
         end
         ST_LOW: begin
            if (count == LOW_LAST) begin
               cnt_clr = 1'b1;
               if (HAS_PULSE) begin
                  state_nx = ST_PULSE;
               end else begin
                  state_nx = ST_IDLE;
                  done_nx  = 1'b1;
               end
            end
         end
         ST_PULSE: begin
            if (count == PULSE_LAST) begin
               cnt_clr  = 1'b1;
               state_nx = ST_IDLE;
               done_nx  = 1'b1;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         bit_q <= 1'b0;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         bit_q <= bit_nx;
         done  <= done_nx;
      end
   end

   // a one never pulls the line low
   assert_one_never_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOW) |-> !bit_q);

   // the bit being driven cannot be altered by a load
   assert_busy_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_LOW) && load) |=> $stable(bit_q));

   // stray edge with nothing loaded keeps the block idle
   assert_idle_edge_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && fall && !load) |=> (state == ST_IDLE) && $stable(done));
endmodule

// File: rtl/sw_dbg_bit_tx.sv
module sw_dbg_bit_tx
   import sw_dbg_bit_pkg::*;
#(
   parameter int LOW_CYCLES   = 13,
   parameter int PULSE_CYCLES = 1,
   parameter int SAMPLE_CYCLE = 10,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic load,
   input  logic load_bit,
   output logic drive_en,
   output logic drive_val,
   output logic done
);
   localparam int SPAN  = (LOW_CYCLES > PULSE_CYCLES) ? LOW_CYCLES : PULSE_CYCLES;
   localparam int CNT_W = $clog2(SPAN + 2);
   localparam int RUN_W = CNT_W + 1;

   initial begin
      if (LOW_CYCLES < 1)            $error("sw_dbg_bit_tx: LOW_CYCLES must be positive");
      if (PULSE_CYCLES < 0)          $error("sw_dbg_bit_tx: PULSE_CYCLES must not be negative");
      if (SAMPLE_CYCLE >= LOW_CYCLES) $error("sw_dbg_bit_tx: low period must outlast the host sample point");
      if (SYNC_STAGES < 2)           $error("sw_dbg_bit_tx: SYNC_STAGES must be at least 2");
   end

   logic             fall;
   logic             cnt_clr;
   logic [CNT_W-1:0] count;
   tx_state_t        state;

   sw_dbg_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_in(pin_in),
      .fall  (fall)
   );

   sw_dbg_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clr),
      .count(count)
   );

   sw_dbg_bit_ctrl #(
      .LOW_CYCLES  (LOW_CYCLES),
      .PULSE_CYCLES(PULSE_CYCLES),
      .CNT_W       (CNT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .fall    (fall),
      .load    (load),
      .load_bit(load_bit),
      .count   (count),
      .cnt_clr (cnt_clr),
      .state   (state),
      .done    (done)
   );

   assign drive_en  = (state == ST_LOW) || (state == ST_PULSE);
   assign drive_val = (state == ST_PULSE);

   // run-length monitors for the driven phases
   logic             low_now, high_now;
   logic [RUN_W-1:0] low_run, high_run;
   assign low_now  = drive_en && !drive_val;
   assign high_now = drive_en && drive_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= '0;
      end else begin
         low_run  <= low_now  ? ((low_run  == '1) ? low_run  : low_run  + 1'b1) : '0;
         high_run <= high_now ? ((high_run == '1) ? high_run : high_run + 1'b1) : '0;
      end
   end

   assert_low_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(low_now) |-> (low_run == RUN_W'(LOW_CYCLES)));

   assert_low_at_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (low_now && (low_run < RUN_W'(SAMPLE_CYCLE))) |=> low_now);

   assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !drive_en);

   generate
      if (PULSE_CYCLES > 0) begin : g_pulse_chk
         assert_pulse_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(high_now) |-> (high_run == RUN_W'(PULSE_CYCLES)) && !drive_en);
         assert_release_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(drive_en) |-> $past(drive_val));
      end else begin : g_nopulse_chk
         assert_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !high_now);
      end
   endgenerate
endmodule

// File: tb/sw_dbg_bit_tx_test.sv
module sw_dbg_bit_tx_test;
   localparam int LOWC = 13;
   localparam int WIN  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_low = 1'b0;
   logic load = 1'b0;
   logic load_bit = 1'b0;
   logic drive_en, drive_val, done;
   logic pin;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic de_r [1:WIN];
   logic dv_r [1:WIN];
   logic dn_r [1:WIN];
   logic pn_r [1:WIN];

   always #4 clk = ~clk;

   assign pin = (host_low || (drive_en && !drive_val)) ? 1'b0 : 1'b1;

   sw_dbg_bit_tx uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin),
      .load     (load),
      .load_bit (load_bit),
      .drive_en (drive_en),
      .drive_val(drive_val),
      .done     (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_load(input logic b);
      @(negedge clk);
      load = 1'b1; load_bit = b;
      @(negedge clk);
      load = 1'b0;
   endtask

   // host pulls the line for two clocks; record WIN negedges afterwards
   task automatic host_bit(input bit busy_load);
      @(negedge clk);
      host_low = 1'b1;
      for (int i = 1; i <= WIN; i++) begin
         @(negedge clk);
         if (i == 2) host_low = 1'b0;
         if (busy_load && i == 5) begin load = 1'b1; load_bit = 1'b1; end
         if (busy_load && i == 6) load = 1'b0;
         de_r[i] = drive_en; dv_r[i] = drive_val; dn_r[i] = done; pn_r[i] = pin;
      end
   endtask

   task automatic check_zero(input string tag);
      int lows = 0;
      for (int i = 1; i <= WIN; i++) if (de_r[i] && !dv_r[i]) lows++;
      chk(!de_r[2], {tag, " R3 no drive before edge k+2"}, de_r[2], 0);
      chk(de_r[3] && !dv_r[3], {tag, " R3 low starts after edge k+2"}, de_r[3], 1);
      chk(lows == LOWC && de_r[15] && !dv_r[15], {tag, " R3 low length"}, lows, LOWC);
      chk(de_r[16] && dv_r[16], {tag, " R4 speedup pulse"}, dv_r[16], 1);
      chk(!de_r[17] && !de_r[20], {tag, " R4 released after one pulse"}, de_r[17], 0);
      chk(pn_r[13] == 1'b0, {tag, " R5 line low at host sample"}, pn_r[13], 0);
      chk(!dn_r[16] && dn_r[17], {tag, " R7 done with release"}, dn_r[17], 1);
   endtask

   task automatic t_reset();
      chk(!drive_en && !done, "R1 during reset", {drive_en, done}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!drive_en && !done, "R1 after reset", {drive_en, done}, 0);
   endtask

   task automatic t_stray_edge_idle();
      host_bit(1'b0);
      int_any_drive("R8 edge with nothing loaded");
      chk(!dn_r[WIN], "R8 done unchanged", dn_r[WIN], 0);
   endtask

   task automatic int_any_drive(input string tag);
      int n = 0;
      for (int i = 1; i <= WIN; i++) if (de_r[i]) n++;
      chk(n == 0, tag, n, 0);
   endtask

   task automatic t_wait_armed();
      do_load(1'b0);
      repeat (10) begin
         @(negedge clk);
         chk(!drive_en && !done, "R2 waits for host edge", drive_en, 0);
      end
      host_bit(1'b0);
      check_zero("zero");
   endtask

   task automatic t_one();
      do_load(1'b1);
      host_bit(1'b0);
      int_any_drive("R6 one never drives");
      chk(!dn_r[2] && dn_r[3], "R6 done after edge k+2", dn_r[3], 1);
   endtask

   task automatic t_done_then_edge();
      host_bit(1'b0);
      int_any_drive("R8 edge after done ignored");
      chk(dn_r[WIN], "R8 done held", dn_r[WIN], 1);
   endtask

   task automatic t_reload();
      do_load(1'b1);
      chk(!done, "R7 load clears done", done, 0);
      do_load(1'b0);
      host_bit(1'b0);
      check_zero("reload R10");
   endtask

   task automatic t_busy_load();
      do_load(1'b0);
      host_bit(1'b1);
      check_zero("busy R9");
      host_bit(1'b0);
      int_any_drive("R9 busy load not armed");
      chk(dn_r[WIN], "R9 done after ignored load", dn_r[WIN], 1);
   endtask

   task automatic t_back_to_back();
      do_load(1'b0);
      host_bit(1'b0);
      check_zero("b2b first");
      do_load(1'b1);
      host_bit(1'b0);
      int_any_drive("R6 second bit one");
      do_load(1'b0);
      host_bit(1'b0);
      check_zero("b2b third");
   endtask

   initial begin
      t_reset();
      t_stray_edge_idle();
      t_wait_armed();
      t_one();
      t_done_then_edge();
      t_reload();
      t_busy_load();
      t_back_to_back();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule